// File: doc/BRIEF.md
# Multichannel Frame-to-I2S Serializer

The serializer takes framed multichannel audio bytes from a synchronous show-ahead FIFO and plays them out as twelve parallel I2S data lines. Each line carries a stereo pair, so the block delivers 24 channels. All lines share one bit clock and one word-select clock, and the block generates the master, bit and word-select clocks itself by dividing its single input clock.

Each frame is a two-byte sync header followed by 72 sample bytes, which is 24 channels of 24 bits. A fetch engine hunts for the header and fills a holding register one byte per clock. It does this only while that register is free. At the start of every left/right cycle, a complete frame moves from the holding register into a playback register, and the serializer reads the playback register. The holding register is then free again, so the next frame is prefetched while the current one plays. If no complete frame is waiting at a cycle start, the block raises an underrun flag and drives silence for that whole cycle.

FIFO access, frame handoff and serialization all run on one clock, so no data crosses between clock domains.

Top module: `mc_i2s_serializer`

## Requirements
- R1: `mclk_o` is the input clock divided by 2. `sck_o` is `mclk_o` divided by 4. `lrck_o` is `sck_o` divided by 64. `lrck_o` low selects the left slot. Every `lrck_o` transition coincides with a falling edge of `sck_o`.
- R2: A frame is header byte 0xA5, then header byte 0x5A, then 72 sample bytes. The sample bytes are channels 0 to 23 in ascending order, three bytes per channel, most significant byte first.
- R3: Data line k (`sd_o[k]`) carries channel 2k in the slot where `lrck_o` is low and channel 2k+1 in the slot where `lrck_o` is high.
- R4: Each slot is 32 bit clocks long. The 24 sample bits go out MSB first in bit positions 1 to 24 of the slot, so the MSB comes one bit clock after the `lrck_o` edge. Positions 0 and 25 to 31 are zero. Data lines change only on falling edges of `sck_o`.
- R5: The FIFO is show-ahead: `fifo_data_i` is valid whenever `fifo_empty_i` is low, and a high `fifo_rd_o` pops one byte at the clock edge. `fifo_rd_o` is asserted only when the FIFO is not empty and the holding register does not already contain a complete frame. The fetch engine takes one byte per clock.
- R6: On each falling edge of `lrck_o`, a complete held frame becomes the frame being played. Frames already queued in the FIFO therefore play in consecutive left/right cycles with no gap.
- R7: If no complete frame is held at a falling edge of `lrck_o`, `underrun_o` goes high and stays high for that whole left/right cycle. It clears at the first falling edge of `lrck_o` where a complete frame is present.
- R8: While `underrun_o` is high, all data lines are zero. A partly received frame is never played.
- R9: Bytes are discarded until 0xA5 is followed directly by 0x5A. A frame with either header byte wrong is dropped, along with its sample bytes. A byte of 0xA5 found where 0x5A was expected is treated as a new first header byte.
- R10: While `rst_i` is high, all clock outputs, data lines, `underrun_o` and `fifo_rd_o` are low, even if the FIFO holds data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master oscillator, twice the MCLK rate |
| rst_i | input | 1 | Synchronous active-high reset |
| fifo_data_i | input | 8 | Show-ahead FIFO head byte |
| fifo_empty_i | input | 1 | FIFO empty flag |
| fifo_rd_o | output | 1 | FIFO pop strobe |
| mclk_o | output | 1 | Master clock output |
| sck_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Word-select clock (low = left) |
| sd_o | output | 12 | Serial data, one stereo pair per line |
| underrun_o | output | 1 | No complete frame at the current cycle start |

## Verification
Assertions check the following on every cycle:
- `lrck_o` and data transitions fall only on bit-clock falling edges.
- `underrun_o` changes only at a left/right cycle start.
- Every data line is silent while underrun is flagged.
- The FIFO is never popped when empty.

Only the bench scenarios can show the rest:
- Bytes land in the right channel, line, slot and bit position.
- Corrupt headers and junk bytes are dropped while valid frames after them still lock.
- A partial frame stays silent.
- Queued frames play back to back while the third frame waits in the FIFO.

// File: rtl/mc_i2s_serializer.sv
module mc_i2s_serializer #(
  parameter int NLINES       = 12,
  parameter int SAMPLE_BYTES = 3,
  parameter int MCLK_LOG     = 1,
  parameter int SCK_LOG      = 2,
  parameter int SLOT_LOG     = 5,
  parameter logic [7:0] SYNC_A = 8'hA5,
  parameter logic [7:0] SYNC_B = 8'h5A
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [7:0]        fifo_data_i,
  input  logic              fifo_empty_i,
  output logic              fifo_rd_o,
  output logic              mclk_o,
  output logic              sck_o,
  output logic              lrck_o,
  output logic [NLINES-1:0] sd_o,
  output logic              underrun_o
);
  localparam int NCH       = 2 * NLINES;
  localparam int NBYTES    = NCH * SAMPLE_BYTES;
  localparam int SW        = 8 * SAMPLE_BYTES;
  localparam int SLOT_BITS = 1 << SLOT_LOG;
  localparam int BIT_LO    = MCLK_LOG + SCK_LOG;
  localparam int CW        = BIT_LO + SLOT_LOG + 1;
  localparam int IW        = $clog2(NBYTES);

  typedef enum logic [1:0] {F_HUNT, F_HDR2, F_BODY} fstate_t;

  logic [CW-1:0] cnt;
  fstate_t       fstate;
  logic [IW-1:0] idx;
  logic          hold_full, play_ok, underrun_q;
  logic [7:0]    hold [NBYTES];
  logic [7:0]    play [NBYTES];

  wire frame_end = &cnt;
  wire [SLOT_LOG-1:0] bpos = cnt[CW-2:BIT_LO];
  wire [SLOT_LOG-1:0] sel  = SLOT_LOG'(SW) - bpos;

  assign mclk_o     = cnt[MCLK_LOG-1];
  assign sck_o      = cnt[BIT_LO-1];
  assign lrck_o     = cnt[CW-1];
  assign underrun_o = underrun_q;
  assign fifo_rd_o  = !rst_i && !fifo_empty_i && !hold_full;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt        <= '0;
      fstate     <= F_HUNT;
      idx        <= '0;
      hold_full  <= 1'b0;
      play_ok    <= 1'b0;
      underrun_q <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (fifo_rd_o) begin
        unique case (fstate)
          F_HUNT: if (fifo_data_i == SYNC_A) fstate <= F_HDR2;
          F_HDR2: begin
            if (fifo_data_i == SYNC_B) begin
              fstate <= F_BODY;
              idx    <= '0;
            end else if (fifo_data_i != SYNC_A) begin
              fstate <= F_HUNT;
            end
          end
          F_BODY: begin
            if (idx == IW'(NBYTES - 1)) begin
              hold_full <= 1'b1;
              fstate    <= F_HUNT;
            end
            idx <= idx + 1'b1;
          end
          default: fstate <= F_HUNT;
        endcase
      end
      if (frame_end) begin
        play_ok    <= hold_full;
        underrun_q <= !hold_full;
        if (hold_full) hold_full <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (fifo_rd_o && fstate == F_BODY) hold[idx] <= fifo_data_i;
    if (!rst_i && frame_end && hold_full) play <= hold;
  end

  for (genvar k = 0; k < NLINES; k++) begin : g_line
    logic [SLOT_BITS-1:0] word;
    always_comb begin
      int base;
      base = (2 * k + int'(lrck_o)) * SAMPLE_BYTES;
      word = '0;
      for (int b = 0; b < SAMPLE_BYTES; b++)
        word[SW-1-8*b -: 8] = play[IW'(base + b)];
    end
    assign sd_o[k] = play_ok && word[sel];
  end

  assert_lrck_on_sck_fall_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    ($rose(lrck_o) || $fell(lrck_o)) |-> $fell(sck_o));

  assert_data_on_sck_fall_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(sd_o) |-> $fell(sck_o));

  assert_read_not_empty_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    fifo_rd_o |-> !fifo_empty_i);

  assert_underrun_at_cycle_start_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(underrun_o) |-> $fell(lrck_o));

  assert_mute_in_underrun_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    underrun_o |-> (sd_o == '0));
endmodule

// File: tb/mc_i2s_serializer_tb.sv
module mc_i2s_serializer_tb;
  localparam int NL = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [7:0] fmem [1024];
  int wp = 0;
  int rp = 0;
  logic          fifo_empty, fifo_rd, mclk, sck, lrck, underrun;
  logic [7:0]    fifo_data;
  logic [NL-1:0] sd;

  assign fifo_empty = (rp == wp);
  assign fifo_data  = fmem[rp % 1024];
  always @(posedge clk) if (fifo_rd && !fifo_empty) rp <= rp + 1;

  mc_i2s_serializer u_dut (
    .clk_i(clk), .rst_i(rst), .fifo_data_i(fifo_data), .fifo_empty_i(fifo_empty),
    .fifo_rd_o(fifo_rd), .mclk_o(mclk), .sck_o(sck), .lrck_o(lrck),
    .sd_o(sd), .underrun_o(underrun));

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [63:0] cap [NL];
  logic        cap_ur;

  // Each row: {kind, seed}. kind 0 = valid frame, 1 = bad first header byte, 2 = bad second header byte.
  localparam logic [9:0] VEC [6] = '{
    {2'd0, 8'h01}, {2'd1, 8'h22}, {2'd0, 8'h3C},
    {2'd2, 8'h47}, {2'd0, 8'hFE}, {2'd0, 8'h80}};

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] gen(input logic [7:0] seed, input int i);
    int v;
    v = int'(seed) * 37 + i * 11 + 3;
    return v[7:0];
  endfunction

  function automatic logic [23:0] smp(input logic [7:0] seed, input int ch);
    return {gen(seed, 3*ch), gen(seed, 3*ch+1), gen(seed, 3*ch+2)};
  endfunction

  function automatic logic [63:0] expline(input logic [7:0] seed, input int k);
    logic [63:0] e;
    logic [23:0] s;
    e = '0;
    for (int p = 0; p < 64; p++) begin
      s = smp(seed, 2*k + p/32);
      if ((p % 32) >= 1 && (p % 32) <= 24) e[p] = s[24 - (p % 32)];
    end
    return e;
  endfunction

  task automatic push(input logic [7:0] b);
    fmem[wp % 1024] = b;
    wp++;
  endtask

  task automatic push_frame(input logic [7:0] seed, input logic [7:0] h0, input logic [7:0] h1,
                            input logic [7:0] mask);
    push(h0);
    push(h1);
    for (int i = 0; i < 72; i++) push(gen(seed, i) & mask);
  endtask

  task automatic wait_frame_start();
    while (lrck !== 1'b1) @(negedge clk);
    while (lrck !== 1'b0) @(negedge clk);
  endtask

  // Entered at the first negedge of a left/right cycle; leaves at the first negedge of the next one.
  task automatic capture();
    cap_ur = underrun;
    for (int k = 0; k < NL; k++) cap[k] = '0;
    for (int c = 0; c < 512; c++) begin
      if (c % 8 == 4)
        for (int k = 0; k < NL; k++) cap[k][c/8] = sd[k];
      @(negedge clk);
    end
  endtask

  task automatic expect_frame(input logic [7:0] seed, input string tag);
    capture();
    chk(cap_ur == 1'b0, {tag, " R7 underrun low with frame"}, 64'(cap_ur), 64'd0);
    for (int k = 0; k < NL; k++)
      chk(cap[k] == expline(seed, k), {tag, " R2/R3/R4 line data"}, cap[k], expline(seed, k));
  endtask

  task automatic expect_mute(input string tag);
    logic [63:0] any;
    capture();
    any = '0;
    for (int k = 0; k < NL; k++) any |= cap[k];
    chk(cap_ur == 1'b1, {tag, " R7 underrun high"}, 64'(cap_ur), 64'd1);
    chk(any == '0, {tag, " R8 lines silent"}, any, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    push(8'h11);
    repeat (4) @(negedge clk);
    // R10: reset state with a byte waiting in the FIFO
    chk({mclk, sck, lrck, underrun, fifo_rd} == 5'b0, "R10 clocks/flags in reset",
        64'({mclk, sck, lrck, underrun, fifo_rd}), 64'd0);
    chk(sd == '0, "R10 data lines in reset", 64'(sd), 64'd0);
    rst = 1'b0;

    // R1: clock ratios over one full left/right cycle
    wait_frame_start();
    begin
      int m_r = 0;
      int s_r = 0;
      int l_hi = 0;
      int bad = 0;
      logic pm, ps, pl;
      pm = mclk; ps = sck; pl = lrck;
      for (int c = 0; c < 512; c++) begin
        if (mclk && !pm) m_r++;
        if (sck && !ps) s_r++;
        if (lrck) l_hi++;
        if (lrck != pl && !(ps && !sck)) bad++;
        pm = mclk; ps = sck; pl = lrck;
        @(negedge clk);
      end
      chk(m_r == 256, "R1 mclk rises per cycle", 64'(m_r), 64'd256);
      chk(s_r == 64, "R1 sck rises per cycle", 64'(s_r), 64'd64);
      chk(l_hi == 256, "R1 lrck high half", 64'(l_hi), 64'd256);
      chk(bad == 0, "R1 lrck edge off sck fall", 64'(bad), 64'd0);
    end
    chk(fifo_empty == 1'b1, "R9 junk byte consumed", 64'(fifo_empty), 64'd1);
    expect_mute("no data");

    // Table walk: one frame per row, started at a cycle boundary
    for (int v = 0; v < 6; v++) begin
      logic [1:0] kind;
      logic [7:0] seed;
      {kind, seed} = VEC[v];
      case (kind)
        2'd0: push_frame(seed, 8'hA5, 8'h5A, 8'hFF);
        2'd1: push_frame(seed, 8'h00, 8'h5A, 8'h7F);
        default: push_frame(seed, 8'hA5, 8'h00, 8'h7F);
      endcase
      expect_mute($sformatf("row %0d before", v));
      if (kind == 2'd0) expect_frame(seed, $sformatf("row %0d", v));
      else expect_mute($sformatf("row %0d R9 bad header dropped", v));
    end

    // R5/R6: three queued frames play back to back; the third waits in the FIFO
    push_frame(8'h90, 8'hA5, 8'h5A, 8'hFF);
    push_frame(8'h91, 8'hA5, 8'h5A, 8'hFF);
    push_frame(8'h92, 8'hA5, 8'h5A, 8'hFF);
    repeat (300) @(negedge clk);
    chk((wp - rp) == 148, "R5 no read while frame held", 64'(wp - rp), 64'd148);
    wait_frame_start();
    expect_frame(8'h90, "R6 first of three");
    expect_frame(8'h91, "R6 second of three");
    expect_frame(8'h92, "R6 third of three");
    expect_mute("R7 after queue drains");

    // R8: partial frame stays silent; completes and plays one cycle later
    push(8'hA5);
    push(8'h5A);
    for (int i = 0; i < 40; i++) push(gen(8'h6B, i));
    expect_mute("partial start");
    for (int i = 40; i < 72; i++) push(gen(8'h6B, i));
    expect_mute("R8 partial frame not played");
    expect_frame(8'h6B, "R8 completed frame");
    expect_mute("after partial");

    // R9: junk before a header, ending in a repeated first header byte
    push(8'hA5); push(8'h13); push(8'h5A); push(8'h77); push(8'hA5);
    push_frame(8'hC3, 8'hA5, 8'h5A, 8'hFF);
    expect_mute("junk start");
    expect_frame(8'hC3, "R9 lock after junk");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule